// File: doc/BRIEF.md
# ABR Resource-Management Cell Builder

This block assembles one 53-octet resource-management cell for available-bit-rate flow control and sends it out one octet per cycle on a byte stream with valid and ready. The caller sets the flag inputs, the three 16-bit rate words and a 32-bit cell header, then pulses start. The block captures these fields on that pulse. It then runs through a fixed octet map. The map inserts the protocol identifier, sends zeros for the unused fields, fills the reserved span with a constant pattern and clears the reserved bits. The block computes a 10-bit CRC while the payload leaves and appends it as a split two-octet trailer.

Framing on the physical layer, generation of header error control and the decision of when to send a cell all belong to the logic around the block. The fifth header octet is sent as a zero placeholder, and a later stage fills in the header check there. Done is high while the last octet is presented.

Top module: `rmcell_builder`

## Requirements
- R1: After reset, and whenever no cell is in progress, out_valid_o and done_o are low.
- R2: A start_i pulse while idle captures all field inputs. out_valid_o rises on the next clock, and exactly 53 octets are then transferred.
- R3: Octets 1 to 4 are hdr_i, most significant octet first. When PTI_FORCE is set, bits 3:1 of octet 4 (the payload-type field) are replaced by 3'b110. Octet 5 is sent as 0x00.
- R4: Octet 6 is the protocol identifier 0x01.
- R5: Octet 7 is {dir_i, bn_i, ci_i, ni_i, 4'b0000}, with dir_i in the most significant bit.
- R6: Octets 8-9, 10-11 and 12-13 carry er_i, ccr_i and mcr_i in that order, high octet first.
- R7: Octets 14 to 21 are 0x00.
- R8: Octets 22 to 51 are each 0x6A.
- R9: The CRC-10 uses generator x^10+x^9+x^5+x^4+x+1, starts at zero and is shifted most significant bit first. It covers octets 6 to 51 followed by six zero bits. Octet 52 is {6'b0, crc[9:8]} and octet 53 is crc[7:0].
- R10: The octet advances only on a clock where out_valid_o and out_ready_i are both high. While ready is low, out_valid_o and out_data_o hold.
- R11: done_o is high exactly while octet 53 is presented. Once that octet is accepted, out_valid_o is low on the next clock.
- R12: A start_i pulse during a cell is ignored. Field inputs changed during a cell do not alter the octets already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one cell when idle |
| dir_i | input | 1 | Direction flag (1 = backward) |
| bn_i | input | 1 | Backward-notification flag |
| ci_i | input | 1 | Congestion flag |
| ni_i | input | 1 | No-increase flag |
| er_i | input | 16 | Explicit rate word |
| ccr_i | input | 16 | Current cell rate word |
| mcr_i | input | 16 | Minimum cell rate word |
| hdr_i | input | 32 | Cell header, first octet in bits 31:24 |
| out_ready_i | input | 1 | Downstream accepts the octet |
| out_valid_o | output | 1 | Octet on out_data_o is valid |
| out_data_o | output | 8 | Cell octet |
| done_o | output | 1 | Final octet of the cell is presented |

## Verification
The hardest case to reach is a stall in the middle of the split CRC trailer. Octet 52 has to show bits that are not yet in the stored remainder, and both trailer octets must stay stable while the consumer holds ready low. The bench has a ready pattern that drops ready for several cycles exactly on octets 52 and 53, and on octet 1. It combines this with a start pulse and changed field inputs in mid-cell, so that a CRC or trailer that depends on live inputs shows up as a mismatch.

// File: rtl/rmcell_pkg.sv
package rmcell_pkg;

   localparam int unsigned RM_OCTET_W = 8;
   localparam int unsigned RM_RATE_W  = 16;
   localparam int unsigned RM_HDR_W   = 32;
   localparam int unsigned RM_CRC_W   = 10;
   localparam int unsigned RM_CELL_LEN = 53;
   localparam int unsigned RM_IDX_W   = $clog2(RM_CELL_LEN);

   localparam logic [RM_CRC_W-1:0] RM_CRC_POLY = 10'h233;

   // zero-based octet positions
   localparam int unsigned POS_HEC      = 4;
   localparam int unsigned POS_PID      = 5;
   localparam int unsigned POS_FLAGS    = 6;
   localparam int unsigned POS_ER       = 7;
   localparam int unsigned POS_CCR      = 9;
   localparam int unsigned POS_MCR      = 11;
   localparam int unsigned POS_ZERO_LO  = 13;
   localparam int unsigned POS_ZERO_HI  = 20;
   localparam int unsigned POS_FILL_LO  = 21;
   localparam int unsigned POS_FILL_HI  = 50;
   localparam int unsigned POS_CRC_HI   = 51;
   localparam int unsigned POS_CRC_LO   = 52;
   localparam int unsigned CRC_PAD_BITS = 6;

   typedef struct packed {
      logic                 dir;
      logic                 bn;
      logic                 ci;
      logic                 ni;
      logic [RM_RATE_W-1:0] er;
      logic [RM_RATE_W-1:0] ccr;
      logic [RM_RATE_W-1:0] mcr;
      logic [RM_HDR_W-1:0]  hdr;
   } rm_fields_t;

   typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} rm_state_e;

   // Serial CRC step, MSB of the data first, nbits of d consumed.
   function automatic logic [RM_CRC_W-1:0] crc10_shift(
      input logic [RM_CRC_W-1:0]   c,
      input logic [RM_OCTET_W-1:0] d,
      input int unsigned           nbits);
      logic [RM_CRC_W-1:0] r;
      logic fb;
      r = c;
      for (int i = 0; i < RM_OCTET_W; i++) begin
         if (i < int'(nbits)) begin
            fb = r[RM_CRC_W-1] ^ d[RM_OCTET_W-1-i];
            r  = {r[RM_CRC_W-2:0], 1'b0};
            if (fb) r = r ^ RM_CRC_POLY;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/rmcell_seq.sv
module rmcell_seq
   import rmcell_pkg::*;
#(
   parameter int unsigned CELL_LEN = RM_CELL_LEN,
   localparam int unsigned IDX_W   = $clog2(CELL_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ready_i,
   output logic             launch_o,
   output logic             adv_o,
   output logic             valid_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

   rm_state_e        state_q;
   logic [IDX_W-1:0] idx_q;

   assign valid_o  = (state_q == ST_SEND);
   assign launch_o = (state_q == ST_IDLE) && start_i;
   assign adv_o    = valid_o && ready_i;
   assign last_o   = valid_o && (idx_q == LAST_IDX);
   assign idx_o    = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else if (launch_o) begin
         state_q <= ST_SEND;
         idx_q   <= '0;
      end else if (adv_o) begin
         if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rmcell_crc.sv
module rmcell_crc
   import rmcell_pkg::*;
#(
   parameter int unsigned IDX_W = RM_IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  adv_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [RM_OCTET_W-1:0] octet_i,
   output logic [RM_CRC_W-1:0]   crc_o,
   output logic [RM_CRC_W-1:0]   crc_padded_o
);

   localparam logic [IDX_W-1:0] COV_LO = IDX_W'(POS_PID);
   localparam logic [IDX_W-1:0] COV_HI = IDX_W'(POS_FILL_HI);
   localparam logic [IDX_W-1:0] PAD_AT = IDX_W'(POS_CRC_HI);

   logic [RM_CRC_W-1:0] crc_q;
   logic                covered;

   assign covered      = (idx_i >= COV_LO) && (idx_i <= COV_HI);
   assign crc_padded_o = crc10_shift(crc_q, '0, CRC_PAD_BITS);
   assign crc_o        = crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (clear_i) begin
         crc_q <= '0;
      end else if (adv_i) begin
         if (covered)
            crc_q <= crc10_shift(crc_q, octet_i, RM_OCTET_W);
         else if (idx_i == PAD_AT)
            crc_q <= crc_padded_o;
      end
   end

endmodule

// File: rtl/rmcell_octet_map.sv
module rmcell_octet_map
   import rmcell_pkg::*;
#(
   parameter int unsigned IDX_W     = RM_IDX_W,
   parameter logic [7:0]  FILL_BYTE = 8'h6A,
   parameter logic [7:0]  PROTO_ID  = 8'h01,
   parameter bit          PTI_FORCE = 1'b1,
   parameter logic [2:0]  PTI_VALUE = 3'b110
) (
   input  rm_fields_t            fields_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [RM_CRC_W-1:0]   crc_i,
   input  logic [RM_CRC_W-1:0]   crc_padded_i,
   output logic [RM_OCTET_W-1:0] octet_o
);

   logic [7:0] hdr_b3;
   logic [7:0] flag_b;
   int unsigned pos;

   generate
      if (PTI_FORCE) begin : g_pti_force
         assign hdr_b3 = {fields_i.hdr[7:4], PTI_VALUE, fields_i.hdr[0]};
      end else begin : g_pti_pass
         assign hdr_b3 = fields_i.hdr[7:0];
      end
   endgenerate

   assign flag_b = {fields_i.dir, fields_i.bn, fields_i.ci, fields_i.ni, 4'b0000};
   assign pos    = 32'(idx_i);

   always_comb begin
      octet_o = 8'h00;
      if (pos == 0)
         octet_o = fields_i.hdr[31:24];
      else if (pos == 1)
         octet_o = fields_i.hdr[23:16];
      else if (pos == 2)
         octet_o = fields_i.hdr[15:8];
      else if (pos == 3)
         octet_o = hdr_b3;
      else if (pos == POS_HEC)
         octet_o = 8'h00;
      else if (pos == POS_PID)
         octet_o = PROTO_ID;
      else if (pos == POS_FLAGS)
         octet_o = flag_b;
      else if (pos == POS_ER)
         octet_o = fields_i.er[15:8];
      else if (pos == POS_ER + 1)
         octet_o = fields_i.er[7:0];
      else if (pos == POS_CCR)
         octet_o = fields_i.ccr[15:8];
      else if (pos == POS_CCR + 1)
         octet_o = fields_i.ccr[7:0];
      else if (pos == POS_MCR)
         octet_o = fields_i.mcr[15:8];
      else if (pos == POS_MCR + 1)
         octet_o = fields_i.mcr[7:0];
      else if (pos >= POS_ZERO_LO && pos <= POS_ZERO_HI)
         octet_o = 8'h00;
      else if (pos >= POS_FILL_LO && pos <= POS_FILL_HI)
         octet_o = FILL_BYTE;
      else if (pos == POS_CRC_HI)
         octet_o = {6'b000000, crc_padded_i[9:8]};
      else if (pos == POS_CRC_LO)
         octet_o = crc_i[7:0];
   end

endmodule

// File: rtl/rmcell_builder.sv
module rmcell_builder
   import rmcell_pkg::*;
#(
   parameter int unsigned CELL_LEN  = 53,
   parameter int unsigned RATE_W    = 16,
   parameter int unsigned HDR_W     = 32,
   parameter logic [7:0]  FILL_BYTE = 8'h6A,
   parameter logic [7:0]  PROTO_ID  = 8'h01,
   parameter bit          PTI_FORCE = 1'b1,
   parameter logic [2:0]  PTI_VALUE = 3'b110
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        dir_i,
   input  logic        bn_i,
   input  logic        ci_i,
   input  logic        ni_i,
   input  logic [15:0] er_i,
   input  logic [15:0] ccr_i,
   input  logic [15:0] mcr_i,
   input  logic [31:0] hdr_i,
   input  logic        out_ready_i,
   output logic        out_valid_o,
   output logic [7:0]  out_data_o,
   output logic        done_o
);

   localparam int unsigned IDX_W = $clog2(CELL_LEN);

   generate
      if (CELL_LEN != RM_CELL_LEN) begin : g_bad_len
         $error("rmcell_builder: CELL_LEN must equal the fixed octet map length");
      end
      if (RATE_W != RM_RATE_W) begin : g_bad_rate
         $error("rmcell_builder: RATE_W must be 16");
      end
      if (HDR_W != RM_HDR_W) begin : g_bad_hdr
         $error("rmcell_builder: HDR_W must be 32");
      end
   endgenerate

   logic             launch;
   logic             adv;
   logic [IDX_W-1:0] idx;
   logic [9:0]       crc;
   logic [9:0]       crc_padded;
   rm_fields_t       fields_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields_q <= '0;
      end else if (launch) begin
         fields_q.dir <= dir_i;
         fields_q.bn  <= bn_i;
         fields_q.ci  <= ci_i;
         fields_q.ni  <= ni_i;
         fields_q.er  <= er_i;
         fields_q.ccr <= ccr_i;
         fields_q.mcr <= mcr_i;
         fields_q.hdr <= hdr_i;
      end
   end

   rmcell_seq #(.CELL_LEN(CELL_LEN)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .ready_i  (out_ready_i),
      .launch_o (launch),
      .adv_o    (adv),
      .valid_o  (out_valid_o),
      .last_o   (done_o),
      .idx_o    (idx)
   );

   rmcell_octet_map #(
      .IDX_W     (IDX_W),
      .FILL_BYTE (FILL_BYTE),
      .PROTO_ID  (PROTO_ID),
      .PTI_FORCE (PTI_FORCE),
      .PTI_VALUE (PTI_VALUE)
   ) map_i (
      .fields_i     (fields_q),
      .idx_i        (idx),
      .crc_i        (crc),
      .crc_padded_i (crc_padded),
      .octet_o      (out_data_o)
   );

   rmcell_crc #(.IDX_W(IDX_W)) crc_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (launch),
      .adv_i        (adv),
      .idx_i        (idx),
      .octet_i      (out_data_o),
      .crc_o        (crc),
      .crc_padded_o (crc_padded)
   );

endmodule

// File: rtl/rmcell_builder_chk.sv
module rmcell_builder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       out_ready_i,
   input logic       out_valid_o,
   input logic [7:0] out_data_o,
   input logic       done_o,
   input logic [5:0] idx
);

   // R1: no done without a cell in progress
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> !done_o);

   // R2: start while idle launches a cell on the next clock
   assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid_o && start_i) |=> out_valid_o);

   // R4: protocol identifier octet
   assert_proto_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && idx == 6'd5) |-> out_data_o == 8'h01);

   // R10: stalled octet holds
   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   // R11: valid drops after the final octet is taken
   assert_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && out_ready_i) |=> !out_valid_o);

   // R12: a cell runs to its end regardless of start
   assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !(done_o && out_ready_i)) |=> out_valid_o);

endmodule

bind rmcell_builder rmcell_builder_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .out_ready_i (out_ready_i),
   .out_valid_o (out_valid_o),
   .out_data_o  (out_data_o),
   .done_o      (done_o),
   .idx         (idx)
);

// File: tb/rmcell_builder_tb_top.sv
`timescale 1ns/1ps
module rmcell_builder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        dir_i = 1'b0, bn_i = 1'b0, ci_i = 1'b0, ni_i = 1'b0;
   logic [15:0] er_i = '0, ccr_i = '0, mcr_i = '0;
   logic [31:0] hdr_i = '0;
   logic        out_ready_i = 1'b0;
   logic        out_valid_o;
   logic [7:0]  out_data_o;
   logic        done_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   logic [7:0] exp_q [0:52];
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   rmcell_builder dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dir_i(dir_i), .bn_i(bn_i), .ci_i(ci_i), .ni_i(ni_i),
      .er_i(er_i), .ccr_i(ccr_i), .mcr_i(mcr_i), .hdr_i(hdr_i),
      .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
      .out_data_o(out_data_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic string tag_of(input int n);
      if (n < 5) return "R3";
      if (n == 5) return "R4";
      if (n == 6) return "R5";
      if (n < 13) return "R6";
      if (n < 21) return "R7";
      if (n < 51) return "R8";
      return "R9";
   endfunction

   // Build the expected cell from the requirement text.
   task automatic build_expected(input logic d, b, c, n, input logic [15:0] er, ccr, mcr,
                                 input logic [31:0] hdr);
      logic [9:0] rem;
      exp_q[0] = hdr[31:24];
      exp_q[1] = hdr[23:16];
      exp_q[2] = hdr[15:8];
      exp_q[3] = {hdr[7:4], 3'b110, hdr[0]};
      exp_q[4] = 8'h00;
      exp_q[5] = 8'h01;
      exp_q[6] = {d, b, c, n, 4'h0};
      exp_q[7] = er[15:8];  exp_q[8]  = er[7:0];
      exp_q[9] = ccr[15:8]; exp_q[10] = ccr[7:0];
      exp_q[11] = mcr[15:8]; exp_q[12] = mcr[7:0];
      for (int k = 13; k <= 20; k++) exp_q[k] = 8'h00;
      for (int k = 21; k <= 50; k++) exp_q[k] = 8'h6A;
      // long division of the covered bit stream by the generator
      rem = '0;
      for (int k = 5; k <= 51; k++) begin
         for (int j = 7; j >= 0; j--) begin
            if (k < 51 || j >= 2) begin
               logic top;
               top = rem[9] ^ ((k < 51) ? exp_q[k][j] : 1'b0);
               rem = {rem[8:0], 1'b0} ^ (top ? 10'b10_0011_0011 : 10'b0);
            end
         end
      end
      exp_q[51] = {6'b0, rem[9:8]};
      exp_q[52] = rem[7:0];
   endtask

   // mode 0: always ready, 1: pseudo-random, 2: stall on octets 1, 52, 53
   task automatic run_cell(input logic [3:0] flags, input logic [15:0] er, ccr, mcr,
                           input logic [31:0] hdr, input int mode, input bit midstart);
      int n = 0;
      int guard = 0;
      int hold = 0;
      bit stalled = 0;
      logic [7:0] held;
      @(negedge clk);
      {dir_i, bn_i, ci_i, ni_i} = flags;
      er_i = er; ccr_i = ccr; mcr_i = mcr; hdr_i = hdr;
      build_expected(flags[3], flags[2], flags[1], flags[0], er, ccr, mcr, hdr);
      start_i = 1'b1;
      out_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      check(out_valid_o === 1'b1, "R2", int'(out_valid_o), 1);
      while (n < 53 && guard < 600) begin
         guard++;
         if (stalled) begin
            check(out_valid_o === 1'b1 && out_data_o === held, "R10", int'(out_data_o), int'(held));
         end
         if (midstart && n == 20) begin
            start_i = 1'b1;
            {dir_i, bn_i, ci_i, ni_i} = ~flags;
            er_i = ~er; ccr_i = ~ccr; mcr_i = ~mcr; hdr_i = ~hdr;
         end else begin
            start_i = 1'b0;
         end
         case (mode)
            0: out_ready_i = 1'b1;
            1: out_ready_i = lfsr[0] | lfsr[5];
            default: begin
               if ((n == 0 || n == 51 || n == 52) && hold < 4) begin
                  out_ready_i = 1'b0;
                  hold++;
               end else begin
                  out_ready_i = 1'b1;
               end
            end
         endcase
         #1;
         if (out_valid_o && out_ready_i) begin
            check(out_data_o === exp_q[n], tag_of(n), int'(out_data_o), int'(exp_q[n]));
            check(done_o === (n == 52), "R11", int'(done_o), int'(n == 52));
            n++;
            hold = 0;
            stalled = 0;
         end else begin
            check(out_valid_o === 1'b1, "R12", int'(out_valid_o), 1);
            stalled = 1;
            held = out_data_o;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      out_ready_i = 1'b0;
      check(n == 53, "R2", n, 53);
      check(out_valid_o === 1'b0 && done_o === 1'b0, "R11", int'(out_valid_o), 0);
      @(negedge clk);
      check(out_valid_o === 1'b0, "R1", int'(out_valid_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid_o === 1'b0, "R1", int'(out_valid_o), 0);
      check(done_o === 1'b0, "R1", int'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid_o === 1'b0, "R1", int'(out_valid_o), 0);
      // sweep every flag combination with varied rates, headers and ready modes
      for (int f = 0; f < 16; f++) begin
         logic [15:0] er, ccr, mcr;
         logic [31:0] hdr;
         er  = 16'(f * 16'h1111) ^ 16'h8001;
         ccr = 16'(16'hFFFF - f * 16'h0F0F);
         mcr = 16'(f * 16'h0301);
         hdr = 32'h0012_3400 | 32'(f * 32'h0101_0103);
         run_cell(4'(f), er, ccr, mcr, hdr, f % 3, 1'b0);
      end
      // all-ones and all-zero boundary fields
      run_cell(4'hF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 2, 1'b0);
      run_cell(4'h0, 16'h0000, 16'h0000, 16'h0000, 32'h0000_0000, 0, 1'b0);
      // start and changed inputs in mid-cell
      run_cell(4'hA, 16'h4D2F, 16'h1234, 16'h00C0, 32'h0ABC_DEF2, 2, 1'b1);
      run_cell(4'h5, 16'h7E00, 16'h3FFF, 16'h0001, 32'h1357_9BDF, 1, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule